// File: doc/BRIEF.md
# General-Purpose Port Register with Pin and Latch Read Paths

This block is the register side of one 8-bit general-purpose I/O port in a microcontroller-style register space. A register bus writes an output latch, either as a whole byte or one bit at a time, and reads back from the port. A plain read returns the synchronized levels seen on the pads. A read flagged as read-modify-write returns the latch instead. Bit writes always merge into the latch value, so bits that are not written keep their driven state whatever the pads show.

Two more registers share the bus. A per-pin output-mode register selects push-pull or open-drain drive for each pin. A routing-control register holds a global weak pull-up disable, a crossbar enable and three enables that route the timer-1, timer-0 and counter inputs from port pins. The block drives per-pin output data, output enable and pull-up enable, and brings the routing enables out to the pin-assignment logic next to it.

Register select (`addr`): 0 selects the port latch, 1 the routing control, 2 the output mode and 3 nothing.

Top module: `port_io_block`

## Requirements
- R1: While `rst` is high and right after it is released, the latch holds 0xFF and both the mode register and the routing control hold 0x00. So `pin_oe` = 0x00, `pin_out` = 0x00, `pin_pu` = 0xFF, every route output is 0 and a read of addr 1 returns 0x00.
- R2: A byte write (`wr_en`=1, `bit_op`=0) to addr 0 loads `wdata` into the latch at the clock edge. On an open-drain pin (mode bit 0), `pin_out` is 0 and `pin_oe` is the inverse of the latch bit from the next cycle on.
- R3: A read of addr 0 with `rmw`=0 returns `pin_in` as sampled two rising edges earlier, whatever the routing control holds.
- R4: A read of addr 0 with `rmw`=1 returns the latch contents, not the pads.
- R5: A bit write (`wr_en`=1, `bit_op`=1) sets bit `bit_sel` of the selected register to `bit_val` and leaves the other bits at their current register value.
- R6: A mode bit of 1 makes its pin push-pull: `pin_oe` = 1 and `pin_out` equals the latch bit.
- R7: `pin_pu[i]` is 1 only when mode bit i is 0 and routing-control bit 7 (pull-up disable) is 0.
- R8: Routing-control bits 5 to 3 read as zero, and writes to them have no effect.
- R9: Routing-control bit 6 drives `xbar_on`, bit 2 drives `t1_route`, bit 1 drives `t0_route` and bit 0 drives `ctr_route`.
- R10: Reads of addr 1 and addr 2 return the routing control and the mode register. Addr 3 reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| bit_op | input | 1 | 1 = single-bit write, 0 = byte write |
| bit_sel | input | 3 | Bit index for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| wdata | input | 8 | Byte write data |
| rmw | input | 1 | Marks the read as read-modify-write (latch source) |
| rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Per-pin output data |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| xbar_on | output | 1 | Crossbar enable |
| t1_route | output | 1 | Timer-1 input routed from a pin |
| t0_route | output | 1 | Timer-0 input routed from a pin |
| ctr_route | output | 1 | Counter input routed from a pin |

## Verification
Register writes land at the clock edge they are sampled on, so pad drive, pull-ups, routes and read data for the control and mode registers are due one cycle later. A pad change reaches the plain port read only after two rising edges. The read path is combinational on `addr` and `rmw`. The bench drives at the falling edge and updates its model once per rising edge, with a two-deep pad history standing in for the synchronizer. It then compares at the next falling edge, so each result is checked in the first cycle it is due. The directed part also checks a pad change on its own: the old level is expected one cycle later and the new level two cycles later.

// File: rtl/port_io_pkg.sv
package port_io_pkg;

    localparam int CTRL_W = 8;
    localparam int ADDR_W = 2;

    // Bits of the routing control that hold state; bits 5..3 are absent.
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 8'hC7;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PORT = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_MODE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Field order is fixed: software decodes these bit positions.
    typedef struct packed {
        logic       pu_off;   // 7: global weak pull-up disable
        logic       xb_on;    // 6: crossbar enable
        logic [2:0] rsvd;     // 5..3: always zero
        logic       t1_in;    // 2
        logic       t0_in;    // 1
        logic       ctr_in;   // 0
    } ctrl_t;

    typedef struct packed {
        logic out;
        logic oe;
        logic pu;
    } pad_t;

    function automatic ctrl_t ctrl_clean(input logic [CTRL_W-1:0] raw);
        return ctrl_t'(raw & CTRL_KEEP);
    endfunction

    // Open-drain: drive low for latch 0, release for latch 1.
    // Push-pull: always driven with the latch value, no pull-up.
    function automatic pad_t pad_drive(input logic lat, input logic pp,
                                       input logic pu_off);
        pad_t p;
        p.out = pp & lat;
        p.oe  = pp | ~lat;
        p.pu  = ~pp & ~pu_off;
        return p;
    endfunction

endpackage

// File: rtl/port_in_sync.sv
module port_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/port_reg_file.sv
module port_reg_file
    import port_io_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  reg_sel_e                 sel,
    input  logic                     wr_en,
    input  logic                     bit_op,
    input  logic [$clog2(WIDTH)-1:0] bit_sel,
    input  logic                     bit_val,
    input  logic [WIDTH-1:0]         wdata,
    output logic [WIDTH-1:0]         latch_q,
    output logic [WIDTH-1:0]         mode_q,
    output ctrl_t                    ctrl_q
);

    // Bit writes merge into the stored register value, never the pads.
    function automatic logic [WIDTH-1:0] merge_wr(
        input logic [WIDTH-1:0]         cur,
        input logic                     is_bit,
        input logic [$clog2(WIDTH)-1:0] idx,
        input logic                     val,
        input logic [WIDTH-1:0]         byte_val
    );
        logic [WIDTH-1:0] v;
        if (is_bit) begin
            v      = cur;
            v[idx] = val;
        end else begin
            v = byte_val;
        end
        return v;
    endfunction

    logic [WIDTH-1:0] latch_nx, mode_nx, ctrl_wide, ctrl_mrg;
    ctrl_t            ctrl_nx;

    always_comb begin
        ctrl_wide = WIDTH'(ctrl_q);
        latch_nx  = merge_wr(latch_q,   bit_op, bit_sel, bit_val, wdata);
        mode_nx   = merge_wr(mode_q,    bit_op, bit_sel, bit_val, wdata);
        ctrl_mrg  = merge_wr(ctrl_wide, bit_op, bit_sel, bit_val, wdata);
        ctrl_nx   = ctrl_clean(ctrl_mrg[CTRL_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '1;
            mode_q  <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_PORT: latch_q <= latch_nx;
                SEL_MODE: mode_q  <= mode_nx;
                SEL_CTRL: ctrl_q  <= ctrl_nx;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/port_pad_ctrl.sv
module port_pad_ctrl
    import port_io_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] mode_q,
    input  logic             pu_off,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pad
        pad_t pd;
        assign pd         = pad_drive(latch_q[i], mode_q[i], pu_off);
        assign pin_out[i] = pd.out;
        assign pin_oe[i]  = pd.oe;
        assign pin_pu[i]  = pd.pu;
    end

endmodule

// File: rtl/port_read_mux.sv
module port_read_mux
    import port_io_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  reg_sel_e         sel,
    input  logic             rmw,
    input  logic [WIDTH-1:0] pins_sync,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] mode_q,
    input  ctrl_t            ctrl_q,
    output logic [WIDTH-1:0] rdata
);

    always_comb begin
        unique case (sel)
            SEL_PORT: rdata = rmw ? latch_q : pins_sync;
            SEL_CTRL: rdata = WIDTH'(ctrl_q);
            SEL_MODE: rdata = mode_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/port_io_block.sv
module port_io_block
    import port_io_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_en,
    input  logic                     bit_op,
    input  logic [$clog2(WIDTH)-1:0] bit_sel,
    input  logic                     bit_val,
    input  logic [WIDTH-1:0]         wdata,
    input  logic                     rmw,
    output logic [WIDTH-1:0]         rdata,
    input  logic [WIDTH-1:0]         pin_in,
    output logic [WIDTH-1:0]         pin_out,
    output logic [WIDTH-1:0]         pin_oe,
    output logic [WIDTH-1:0]         pin_pu,
    output logic                     xbar_on,
    output logic                     t1_route,
    output logic                     t0_route,
    output logic                     ctr_route
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] mode_q;
    ctrl_t            ctrl_q;

    assign sel = reg_sel_e'(addr);

    port_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_sync)
    );

    port_reg_file #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wr_en   (wr_en),
        .bit_op  (bit_op),
        .bit_sel (bit_sel),
        .bit_val (bit_val),
        .wdata   (wdata),
        .latch_q (latch_q),
        .mode_q  (mode_q),
        .ctrl_q  (ctrl_q)
    );

    port_pad_ctrl #(.WIDTH(WIDTH)) u_pads (
        .latch_q (latch_q),
        .mode_q  (mode_q),
        .pu_off  (ctrl_q.pu_off),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_pu  (pin_pu)
    );

    port_read_mux #(.WIDTH(WIDTH)) u_rd (
        .sel       (sel),
        .rmw       (rmw),
        .pins_sync (pins_sync),
        .latch_q   (latch_q),
        .mode_q    (mode_q),
        .ctrl_q    (ctrl_q),
        .rdata     (rdata)
    );

    assign xbar_on   = ctrl_q.xb_on;
    assign t1_route  = ctrl_q.t1_in;
    assign t0_route  = ctrl_q.t0_in;
    assign ctr_route = ctrl_q.ctr_in;

endmodule

// File: rtl/port_io_chk.sv
module port_io_chk #(
    parameter int WIDTH = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic [1:0]               addr,
    input logic                     wr_en,
    input logic                     bit_op,
    input logic [$clog2(WIDTH)-1:0] bit_sel,
    input logic                     bit_val,
    input logic [WIDTH-1:0]         wdata,
    input logic                     rmw,
    input logic [WIDTH-1:0]         rdata,
    input logic [WIDTH-1:0]         pin_in,
    input logic [WIDTH-1:0]         pin_out,
    input logic [WIDTH-1:0]         pin_oe,
    input logic [WIDTH-1:0]         pin_pu,
    input logic [WIDTH-1:0]         latch_q,
    input logic [WIDTH-1:0]         mode_q,
    input logic [7:0]               ctrl_q
);

    // Edges since reset release, saturating; gates the pad-history check.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (latch_q == '1 && mode_q == '0 && ctrl_q == 8'h00));

    p_byte_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !bit_op && addr == 2'd0) |=> latch_q == $past(wdata));

    p_open_drain_r2: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe ^ ~latch_q) & ~mode_q) == '0 && (pin_out & ~mode_q) == '0);

    p_pin_delay_r3: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && addr == 2'd0 && !rmw) |-> rdata == $past(pin_in, 2));

    p_rmw_latch_r4: assert property (@(posedge clk) disable iff (rst)
        (addr == 2'd0 && rmw) |-> rdata == latch_q);

    p_bit_write_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bit_op && addr == 2'd0) |=>
        (latch_q[$past(bit_sel)] == $past(bit_val) &&
         $countones(latch_q ^ $past(latch_q)) <= 1));

    p_push_pull_r6: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & mode_q) == mode_q && ((pin_out ^ latch_q) & mode_q) == '0);

    p_pullup_mode_r7: assert property (@(posedge clk) disable iff (rst)
        (pin_pu & mode_q) == '0);

    p_pullup_off_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[7] |-> pin_pu == '0);

    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
        addr == 2'd1 |-> rdata[5:3] == 3'b000);

    p_none_zero_r10: assert property (@(posedge clk) disable iff (rst)
        addr == 2'd3 |-> rdata == '0);

endmodule

bind port_io_block port_io_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .bit_op  (bit_op),
    .bit_sel (bit_sel),
    .bit_val (bit_val),
    .wdata   (wdata),
    .rmw     (rmw),
    .rdata   (rdata),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_pu  (pin_pu),
    .latch_q (latch_q),
    .mode_q  (mode_q),
    .ctrl_q  (8'(ctrl_q))
);

// File: tb/tb_port_io_block.sv
module tb_port_io_block;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   addr;
    logic         wr_en, bit_op, bit_val, rmw;
    logic [2:0]   bit_sel;
    logic [W-1:0] wdata, pin_in;
    logic [W-1:0] rdata, pin_out, pin_oe, pin_pu;
    logic         xbar_on, t1_route, t0_route, ctr_route;

    int total = 0;
    int fails = 0;

    // Bench model state
    logic [7:0] m_latch, m_mode, m_ctrl, m_s1, m_s2;

    always #5 clk = ~clk;

    port_io_block dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .bit_op(bit_op),
        .bit_sel(bit_sel), .bit_val(bit_val), .wdata(wdata), .rmw(rmw),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pu(pin_pu), .xbar_on(xbar_on), .t1_route(t1_route),
        .t0_route(t0_route), .ctr_route(ctr_route)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] merge(input logic [7:0] cur);
        logic [7:0] v;
        if (bit_op) begin v = cur; v[bit_sel] = bit_val; end
        else v = wdata;
        return v;
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_latch = 8'hFF; m_mode = 8'h00; m_ctrl = 8'h00;
            m_s1 = 8'h00;    m_s2 = 8'h00;
        end else begin
            m_s2 = m_s1;
            m_s1 = pin_in;
            if (wr_en) begin
                case (addr)
                    2'd0: m_latch = merge(m_latch);
                    2'd1: m_ctrl  = merge(m_ctrl) & 8'hC7;  // R8 bits 5..3 dropped
                    2'd2: m_mode  = merge(m_mode);
                    default: ;                              // R10 no register
                endcase
            end
        end
    endtask

    task automatic check_all();
        logic [7:0] e_rd, e_out, e_oe, e_pu;
        string      t_rd;
        case (addr)
            2'd0: begin e_rd = rmw ? m_latch : m_s2; t_rd = rmw ? "R4 rmw read" : "R3 pin read"; end
            2'd1: begin e_rd = m_ctrl; t_rd = "R8 R10 ctrl read"; end
            2'd2: begin e_rd = m_mode; t_rd = "R10 mode read"; end
            default: begin e_rd = 8'h00; t_rd = "R10 empty read"; end
        endcase
        e_out = m_mode & m_latch;
        e_oe  = m_mode | ~m_latch;
        e_pu  = ~m_mode & {8{~m_ctrl[7]}};
        chk(t_rd, rdata, e_rd);
        chk("R2 R6 pin_out", pin_out, e_out);
        chk("R2 R6 pin_oe", pin_oe, e_oe);
        chk("R7 pin_pu", pin_pu, e_pu);
        chk("R9 routes", {4'b0, xbar_on, t1_route, t0_route, ctr_route},
            {4'b0, m_ctrl[6], m_ctrl[2], m_ctrl[1], m_ctrl[0]});
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic drive(input logic [1:0] a, input logic w, input logic bo,
                         input logic [2:0] bs, input logic bv, input logic [7:0] wd,
                         input logic rm, input logic [7:0] pin);
        addr = a; wr_en = w; bit_op = bo; bit_sel = bs; bit_val = bv;
        wdata = wd; rmw = rm; pin_in = pin;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #2_000_000;
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        rst = 1'b1;
        drive(2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 8'h00);
        tick(); tick();
        // R1 reset state, literal values
        chk("R1 pin_oe reset", pin_oe, 8'h00);
        chk("R1 pin_pu reset", pin_pu, 8'hFF);
        chk("R1 pin_out reset", pin_out, 8'h00);
        chk("R1 ctrl reset", rdata, 8'h00);
        rst = 1'b0;
        tick();
        drive(2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 8'h00);
        tick();
        chk("R1 latch after reset", rdata, 8'hFF);

        // R2 byte write, R4 latch read while pads differ
        drive(2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 8'h5A, 1'b0, 8'h00);
        tick();
        chk("R2 pin_oe open-drain", pin_oe, 8'hA5);
        drive(2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 8'h00);
        tick();
        chk("R4 rmw returns latch", rdata, 8'h5A);

        // R3 pad latency: old level one edge later, new level two edges later
        drive(2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 8'h3C);
        tick();
        chk("R3 one edge, old level", rdata, 8'h00);
        tick();
        chk("R3 two edges, new level", rdata, 8'h3C);

        // R5 bit writes merge into the latch, not the pads (pads 0x3C)
        drive(2'd0, 1'b1, 1'b1, 3'd0, 1'b1, 8'h00, 1'b1, 8'h3C);
        tick();
        drive(2'd0, 1'b1, 1'b1, 3'd6, 1'b0, 8'hFF, 1'b1, 8'h3C);
        tick();
        drive(2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b1, 8'h3C);
        tick();
        chk("R5 bit writes", rdata, 8'h1B);

        // R6 push-pull on upper nibble, R7 pull-ups only on open-drain pins
        drive(2'd2, 1'b1, 1'b0, 3'd0, 1'b0, 8'hF0, 1'b0, 8'h3C);
        tick();
        chk("R6 pin_oe push-pull", pin_oe, 8'hF4);
        chk("R6 pin_out push-pull", pin_out, 8'h10);
        chk("R7 pull-ups open-drain only", pin_pu, 8'h0F);

        // R8 reserved bits, R9 routes, R7 global pull-up disable
        drive(2'd1, 1'b1, 1'b0, 3'd0, 1'b0, 8'hFF, 1'b0, 8'h3C);
        tick();
        chk("R8 ctrl reads 0xC7", rdata, 8'hC7);
        chk("R7 all pull-ups off", pin_pu, 8'h00);
        chk("R9 routes on", {4'b0, xbar_on, t1_route, t0_route, ctr_route}, 8'h0F);
        drive(2'd1, 1'b1, 1'b1, 3'd4, 1'b1, 8'h00, 1'b0, 8'h3C);
        tick();
        chk("R8 reserved bit write ignored", rdata, 8'hC7);
        drive(2'd1, 1'b1, 1'b0, 3'd0, 1'b0, 8'h38, 1'b0, 8'h3C);
        tick();
        chk("R8 only reserved bits written", rdata, 8'h00);

        // R10 empty address: write ignored, reads zero
        drive(2'd3, 1'b1, 1'b0, 3'd0, 1'b0, 8'hAA, 1'b0, 8'h3C);
        tick();
        chk("R10 empty address reads 0", rdata, 8'h00);
        drive(2'd2, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00, 1'b0, 8'h3C);
        tick();
        chk("R10 mode unchanged", rdata, 8'hF0);

        // Constrained random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            drive(2'($urandom_range(0, 3)), ($urandom_range(0, 2) == 0),
                  1'($urandom), 3'($urandom), 1'($urandom), 8'($urandom),
                  1'($urandom), 8'($urandom));
            tick();
        end

        summary();
        $finish;
    end

endmodule